// File: doc/BRIEF.md
# Partial timestamp extender

A receive path often records only the low 24 or 32 bits of the time at which a frame arrived. This block rebuilds the full 64-bit time value from such a truncated capture. It reads a free-running 64-bit time counter in the same cycle that the capture is offered. The low part of the result is the captured value, unchanged. The high part comes from the counter reading, lowered by one wrap period when the counter's low field has wrapped since the capture.

Each capture comes with a valid strobe and a width select. The rebuilt value appears one clock later with its own one-cycle valid strobe. A small two-state controller, `ST_IDLE` and `ST_PRESENT`, sequences the output. The transition `accept` (valid strobe high) enters or stays in `ST_PRESENT`. The transition `drain` (valid strobe low) returns to `ST_IDLE`. The result is correct only when the capture is less than one wrap period older than the counter reading. That limit is assumed and is not detected.

Top module: `ts_extender`

## Requirements
- R1: After reset, `ext_valid` is 0, `ext_ts` is 0 and the controller is in `ST_IDLE`.
- R2: A cycle with `part_valid`=1 produces `ext_valid`=1 on the next clock edge. A cycle with `part_valid`=0 produces `ext_valid`=0 on the next edge. Back-to-back captures give back-to-back results.
- R3: Width select encoding: `part_wide`=0 selects a 24-bit capture in `part_ts[23:0]`, and `part_wide`=1 selects a 32-bit capture in `part_ts[31:0]`. The select is sampled in the same cycle as `part_valid`.
- R4: In 24-bit mode, `part_ts[31:24]` has no effect on the result.
- R5: The low W bits of `ext_ts` (W = 24 or 32) equal the captured W bits, unchanged.
- R6: The upper 64-W bits of `ext_ts` equal `now_time[63:W]` sampled with `part_valid` when the captured W bits are less than or equal to `now_time[W-1:0]`. Otherwise they equal that value minus one, which subtracts one wrap period of 2^W.
- R7: In all cases `ext_ts` is the largest value T ≤ `now_time` with T mod 2^W equal to the capture, computed modulo 2^64. When the counter's upper part is zero and a wrap is detected, the result therefore wraps to the top of the 64-bit range.
- R8: While `ext_valid` is 0, `ext_ts` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_valid | input | 1 | Capture offered this cycle |
| part_ts | input | 32 | Truncated capture, right-aligned |
| part_wide | input | 1 | 0 = 24-bit capture, 1 = 32-bit capture |
| now_time | input | 64 | Current value of the free-running time counter |
| ext_valid | output | 1 | Rebuilt timestamp valid, one cycle |
| ext_ts | output | 64 | Rebuilt 64-bit timestamp |

## Verification
Two functions can fall in the same cycle. The first is the `accept` transition, which loads a new capture. The second is the presentation of the previous result, with or without a wrap correction. The bench provokes this by streaming captures on consecutive cycles, switching width and wrap condition between neighbours. It judges every output cycle against an arithmetic reference: `now - ((now - capture) mod 2^W)`. Gaps in the stream check that the output falls back to idle and holds its value.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;
    localparam int TIME_W   = 64;
    localparam int NARROW_W = 24;
    localparam int WIDE_W   = 32;
    localparam int PART_W   = WIDE_W;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ext_state_e;
endpackage

// File: rtl/ts_ext_lane.sv
module ts_ext_lane #(
    parameter int TW = 64,
    parameter int PW = 32,
    parameter int W  = 24
) (
    input  logic [PW-1:0] part,
    input  logic [TW-1:0] now,
    output logic [TW-1:0] cand
);
    localparam int HI_W = TW - W;

    logic [W-1:0]    cap_lo;
    logic [W-1:0]    now_lo;
    logic [HI_W-1:0] now_hi;
    logic            wrapped;

    always_comb begin
        cap_lo  = part[W-1:0];
        now_lo  = now[W-1:0];
        now_hi  = now[TW-1:W];
        wrapped = cap_lo > now_lo;
        cand    = {now_hi - HI_W'(wrapped), cap_lo};
    end
endmodule

// File: rtl/ts_ext_select.sv
module ts_ext_select #(
    parameter int TW = 64,
    parameter int PW = 32,
    parameter int NW = 24,
    parameter int WW = 32
) (
    input  logic [PW-1:0] part,
    input  logic          wide,
    input  logic [TW-1:0] now,
    output logic [TW-1:0] result
);
    localparam int LANES = 2;
    localparam int LANE_W [LANES] = '{NW, WW};

    logic [TW-1:0] cand [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ts_ext_lane #(.TW(TW), .PW(PW), .W(LANE_W[g])) u_lane (
            .part (part),
            .now  (now),
            .cand (cand[g])
        );
    end

    always_comb result = wide ? cand[1] : cand[0];
endmodule

// File: rtl/ts_extender.sv
module ts_extender
    import ts_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              part_valid,
    input  logic [PART_W-1:0] part_ts,
    input  logic              part_wide,
    input  logic [TIME_W-1:0] now_time,
    output logic              ext_valid,
    output logic [TIME_W-1:0] ext_ts
);
    ext_state_e    state, state_nx;
    logic [TIME_W-1:0] merged;
    logic [TIME_W-1:0] result_q;

    ts_ext_select #(.TW(TIME_W), .PW(PART_W), .NW(NARROW_W), .WW(WIDE_W)) u_sel (
        .part   (part_ts),
        .wide   (part_wide),
        .now    (now_time),
        .result (merged)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (part_valid)  state_nx = ST_PRESENT;
            ST_PRESENT: if (!part_valid) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          result_q <= '0;
        else if (part_valid) result_q <= merged;
    end

    always_comb begin
        ext_valid = (state == ST_PRESENT);
        ext_ts    = result_q;
    end

    assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        part_valid |=> ext_valid);
    assert_drain_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !part_valid |=> !ext_valid);
    assert_wide_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (part_valid && part_wide) |=> (ext_ts[WIDE_W-1:0] == $past(part_ts[WIDE_W-1:0])));
    assert_narrow_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (part_valid && !part_wide) |=> (ext_ts[NARROW_W-1:0] == $past(part_ts[NARROW_W-1:0])));
    assert_not_after_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (part_valid && now_time[TIME_W-1:WIDE_W] != '0) |=> (ext_ts <= $past(now_time)));
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !part_valid |=> $stable(ext_ts));
endmodule

// File: tb/tb_ts_extender.sv
module tb_ts_extender;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        part_valid = 1'b0;
    logic [31:0] part_ts = '0;
    logic        part_wide = 1'b0;
    logic [63:0] now_time = '0;
    logic        ext_valid;
    logic [63:0] ext_ts;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        pend = 1'b0;
    logic [63:0] pend_exp = '0;
    logic [63:0] last_exp = '0;
    logic [63:0] lfsr = 64'h1234_5678_9abc_def1;

    always #2 clk = ~clk;

    ts_extender dut (.*);

    function automatic logic [63:0] ref_ext(logic [63:0] now, logic [31:0] p, logic wide);
        logic [63:0] mask, diff;
        mask = wide ? 64'hffff_ffff : 64'h00ff_ffff;
        diff = (now - {32'h0, p}) & mask;
        return now - diff;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge: check the output from the previous cycle, then drive this one.
    task automatic step(input logic v, input logic [31:0] p, input logic w, input logic [63:0] now);
        if (pend) begin
            chk("R2 valid", {63'h0, ext_valid}, 64'h1);
            chk("R5/R6/R7 value", ext_ts, pend_exp);
            last_exp = pend_exp;
        end else begin
            chk("R2 idle", {63'h0, ext_valid}, 64'h0);
            chk("R8 hold", ext_ts, last_exp);
        end
        part_valid = v; part_ts = p; part_wide = w; now_time = now;
        pend = v;
        if (v) pend_exp = ref_ext(now, w ? p : {8'h0, p[23:0]}, w);
        @(negedge clk);
    endtask

    function automatic logic [63:0] nxt(logic [63:0] x);
        return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid", {63'h0, ext_valid}, 64'h0);
        chk("R1 ts", ext_ts, 64'h0);
        @(negedge clk);
        // Boundary sweep: capture low field vs counter low field around equality and edges.
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < 6; a++) begin
                for (int b = 0; b < 6; b++) begin
                    logic [31:0] edges [6];
                    logic [63:0] nw;
                    logic [31:0] cap;
                    edges = '{32'h0, 32'h1, 32'h7f_ffff, 32'hff_fffe, 32'hff_ffff, 32'hffff_ffff};
                    cap = edges[a];
                    nw  = {32'h0000_0005, 32'h0} | {32'h0, (w == 1) ? edges[b] : {8'h0, edges[b][23:0]}};
                    step(1'b1, cap, w[0], nw);      // R6 wrap / no-wrap, R3 width select
                end
            end
        end
        step(1'b0, '0, 1'b0, '0);                   // R8 gap
        step(1'b0, 32'hffff_ffff, 1'b1, '1);        // R8 inputs change while idle
        // R7: upper part zero with wrap -> result wraps to top of range
        step(1'b1, 32'h10, 1'b0, 64'h5);
        step(1'b1, 32'h10, 1'b1, 64'h5);
        // R4: junk in upper byte in narrow mode, compared with the clean capture
        step(1'b1, 32'hab12_3456, 1'b0, 64'h0000_0001_0012_0000);
        step(1'b1, 32'h0012_3456, 1'b0, 64'h0000_0001_0012_0000);
        // Back-to-back pseudo-random stream with mixed widths and gaps (R2)
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] nw;
            lfsr = nxt(lfsr);
            nw = lfsr;
            lfsr = nxt(lfsr);
            step(lfsr[7:0] != 8'h0, lfsr[40:9], lfsr[50], nw);
        end
        step(1'b0, '0, 1'b0, '0);
        step(1'b0, '0, 1'b0, '0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule